// File: doc/BRIEF.md
# Partial-Volume Joint Histogram Accumulator

This block builds a two-dimensional joint intensity histogram between a reference volume and a floating volume, using partial-volume interpolation. The upstream pipeline hands over one event per voxel that mapped inside the floating volume. Each event carries the reference intensity, the intensities of the eight floating neighbours around the transformed position, and eight fractional weights. The block does not form an interpolated intensity. Instead, each of the eight weights is added to the bin whose row comes from the reference intensity and whose column comes from the matching neighbour's intensity.

A run has three phases. A clear command zeroes the whole bin memory and signals completion. Voxel events are then offered on a valid/ready port, and each one is applied as eight read-modify-write passes over on-chip memory. A readout command finally streams every bin, in row-major order, over a second valid/ready port to the entropy stage.

Top module: `pv_joint_hist`

## Requirements
- R1: After reset, `vx_ready` is 1, `ro_valid` is 0, `ro_last` is 0 and `clr_done` is 0.
- R2: A `clr_start` pulse taken while idle writes zero to all 4096 bins. `clr_done` is a one-cycle pulse seen exactly 4096 clock edges after the edge that took the command. `vx_ready` stays low during the clear, so a voxel event offered then has no effect on any bin.
- R3: The bin index is row*64 + column. The row is bits [7:2] of `vx_ref`, the column is bits [7:2] of the neighbour intensity, and the two low bits of each intensity have no effect on the bin.
- R4: An accepted event adds weight lane k (`vx_wgt[8k+7:8k]`, unsigned) to the bin addressed by neighbour lane k (`vx_flt[8k+7:8k]`), for every k from 0 to 7.
- R5: When several lanes of one event address the same bin, every one of their weights is added to that bin.
- R6: A bin saturates at 65535 rather than wrapping.
- R7: `vx_ready` is high only while the block is idle and neither `clr_start` nor `ro_start` is asserted. After an event is accepted, `vx_ready` is low for exactly 16 cycles.
- R8: A `ro_start` pulse taken while idle raises `ro_valid` one cycle later. Bins 0 to 4095 are then delivered in row-major order, one per handshake, with `ro_last` high on bin 4095 only. After that, the block returns to idle.
- R9: While `ro_valid` is high and `ro_ready` is low, `ro_data` and `ro_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_start | input | 1 | Start zeroing all bins (taken when idle) |
| clr_done | output | 1 | One-cycle pulse when the clear has finished |
| vx_valid | input | 1 | Voxel event offered |
| vx_ready | output | 1 | Voxel event can be accepted |
| vx_ref | input | 8 | Reference intensity |
| vx_flt | input | 64 | Eight neighbour intensities, lane k at bits [8k+7:8k] |
| vx_wgt | input | 64 | Eight weights with 8 fractional bits, lane k at bits [8k+7:8k] |
| ro_start | input | 1 | Start streaming all bins (taken when idle) |
| ro_valid | output | 1 | Readout word available |
| ro_ready | input | 1 | Consumer accepts the readout word |
| ro_data | output | 16 | Bin value |
| ro_last | output | 1 | Marks bin 4095 |

## Verification
An accepted event keeps `vx_ready` low for 16 cycles, and its eight updates can be read back once `vx_ready` returns. `clr_done` is due 4096 edges after the clear command's edge, and the first readout word is due one edge after `ro_start`. Inputs are driven on falling edges and outputs are sampled on falling edges, so each of these delays is counted in whole edges: the bench counts the edges while waiting and compares the count to the value the requirement gives. All 4096 bins are compared with an arithmetic model, under a readout pattern that stalls `ro_ready` periodically.

// File: rtl/pvh_pkg.sv
// Shared types for the partial-volume joint histogram accumulator.
package pvh_pkg;
    // Controller phases: clear sweep, update read, update write, readout.
    typedef enum logic [2:0] {
        PVH_IDLE,
        PVH_CLEAR,
        PVH_UPD_RD,
        PVH_UPD_WR,
        PVH_RD_HOLD
    } pvh_state_t;
endpackage

// File: rtl/pvh_bin_ram.sv
// Single-port bin memory with a registered read.
// Assumes a read and a write are never requested in the same cycle.
// The read register holds its value while no read is requested.
module pvh_bin_ram #(
    parameter int AW    = 12,
    parameter int BIN_W = 16
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr_i,
    input  logic             we_i,
    input  logic [BIN_W-1:0] wd_i,
    input  logic             re_i,
    output logic [BIN_W-1:0] rd_o
);
    localparam int DEPTH = 1 << AW;

    logic [BIN_W-1:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wd_i;
        if (re_i) rd_o <= mem[addr_i];
    end
endmodule

// File: rtl/pvh_lane_sel.sv
// Picks one neighbour lane of the latched event and forms its bin
// address from the top IDX_W bits of both intensities, plus its weight.
module pvh_lane_sel #(
    parameter int INT_W = 8,
    parameter int IDX_W = 6,
    parameter int WGT_W = 8,
    parameter int NNB   = 8,
    parameter int LW    = 3
) (
    input  logic [INT_W-1:0]     ref_i,
    input  logic [NNB*INT_W-1:0] flt_i,
    input  logic [NNB*WGT_W-1:0] wgt_i,
    input  logic [LW-1:0]        lane_i,
    output logic [2*IDX_W-1:0]   addr_o,
    output logic [WGT_W-1:0]     wgt_o
);
    logic [INT_W-1:0] flt_lane [NNB];
    logic [WGT_W-1:0] wgt_lane [NNB];

    for (genvar k = 0; k < NNB; k++) begin : g_unpack
        assign flt_lane[k] = flt_i[k*INT_W +: INT_W];
        assign wgt_lane[k] = wgt_i[k*WGT_W +: WGT_W];
    end

    // Row from the reference intensity, column from the selected neighbour.
    always_comb begin
        addr_o = {ref_i[INT_W-1 -: IDX_W], flt_lane[lane_i][INT_W-1 -: IDX_W]};
        wgt_o  = wgt_lane[lane_i];
    end
endmodule

// File: rtl/pvh_sat_add.sv
// Adds an unsigned weight to a bin count, clamping at the all-ones value.
module pvh_sat_add #(
    parameter int BIN_W = 16,
    parameter int WGT_W = 8
) (
    input  logic [BIN_W-1:0] acc_i,
    input  logic [WGT_W-1:0] wgt_i,
    output logic [BIN_W-1:0] sum_o
);
    logic [BIN_W:0] wide;

    // One extra bit catches the carry that would otherwise wrap.
    always_comb begin
        wide  = {1'b0, acc_i} + (BIN_W+1)'(wgt_i);
        sum_o = wide[BIN_W] ? {BIN_W{1'b1}} : wide[BIN_W-1:0];
    end
endmodule

// File: rtl/pv_joint_hist.sv
// Partial-volume joint histogram accumulator.
// Commands (clear, readout) are taken only while idle, and take priority over
// a voxel event offered in the same cycle. Each accepted event is applied as
// NNB serialized read/write pairs, so bins shared by lanes never race.
// Assumes the bin memory contents are undefined until a clear has finished.
module pv_joint_hist
    import pvh_pkg::*;
#(
    parameter int INT_W = 8,
    parameter int IDX_W = 6,
    parameter int WGT_W = 8,
    parameter int BIN_W = 16,
    parameter int NNB   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_start,
    output logic                 clr_done,
    input  logic                 vx_valid,
    output logic                 vx_ready,
    input  logic [INT_W-1:0]     vx_ref,
    input  logic [NNB*INT_W-1:0] vx_flt,
    input  logic [NNB*WGT_W-1:0] vx_wgt,
    input  logic                 ro_start,
    output logic                 ro_valid,
    input  logic                 ro_ready,
    output logic [BIN_W-1:0]     ro_data,
    output logic                 ro_last
);
    localparam int AW    = 2 * IDX_W;
    localparam int NBINS = 1 << AW;
    localparam int LW    = (NNB > 1) ? $clog2(NNB) : 1;
    localparam logic [AW-1:0] LAST_BIN  = AW'(NBINS - 1);
    localparam logic [LW-1:0] LAST_LANE = LW'(NNB - 1);

    pvh_state_t           state;
    logic [AW-1:0]        cnt;
    logic [LW-1:0]        lane;
    logic [INT_W-1:0]     ref_q;
    logic [NNB*INT_W-1:0] flt_q;
    logic [NNB*WGT_W-1:0] wgt_q;
    logic                 clr_done_q;

    logic [AW-1:0]    cur_addr;
    logic [WGT_W-1:0] cur_wgt;
    logic [BIN_W-1:0] ram_q;
    logic [BIN_W-1:0] sum_val;
    logic [AW-1:0]    ram_addr;
    logic             ram_we;
    logic             ram_re;
    logic [BIN_W-1:0] ram_wd;
    logic             upd_wr_s;
    logic             at_last_bin;

    pvh_lane_sel #(
        .INT_W(INT_W), .IDX_W(IDX_W), .WGT_W(WGT_W), .NNB(NNB), .LW(LW)
    ) u_sel (
        .ref_i(ref_q), .flt_i(flt_q), .wgt_i(wgt_q), .lane_i(lane),
        .addr_o(cur_addr), .wgt_o(cur_wgt)
    );

    pvh_sat_add #(.BIN_W(BIN_W), .WGT_W(WGT_W)) u_add (
        .acc_i(ram_q), .wgt_i(cur_wgt), .sum_o(sum_val)
    );

    pvh_bin_ram #(.AW(AW), .BIN_W(BIN_W)) u_ram (
        .clk(clk), .addr_i(ram_addr), .we_i(ram_we), .wd_i(ram_wd),
        .re_i(ram_re), .rd_o(ram_q)
    );

    // Handshake outputs derived from the controller phase.
    always_comb begin
        at_last_bin = (cnt == LAST_BIN);
        upd_wr_s    = (state == PVH_UPD_WR);
        vx_ready    = (state == PVH_IDLE) && !clr_start && !ro_start;
        ro_valid    = (state == PVH_RD_HOLD);
        ro_last     = ro_valid && at_last_bin;
        ro_data     = ram_q;
        clr_done    = clr_done_q;
    end

    // Memory port arbitration: one access per cycle, chosen by phase.
    always_comb begin
        ram_addr = cur_addr;
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        ram_wd   = sum_val;
        unique case (state)
            PVH_IDLE: begin
                if (!clr_start && ro_start) begin
                    ram_addr = '0;
                    ram_re   = 1'b1;
                end
            end
            PVH_CLEAR: begin
                ram_addr = cnt;
                ram_we   = 1'b1;
                ram_wd   = '0;
            end
            PVH_UPD_RD: ram_re = 1'b1;
            PVH_UPD_WR: ram_we = 1'b1;
            PVH_RD_HOLD: begin
                ram_addr = cnt + AW'(1);
                ram_re   = ro_ready && !at_last_bin;
            end
            default: ;
        endcase
    end

    // Controller: phase, bin counter, lane counter and latched event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PVH_IDLE;
            cnt        <= '0;
            lane       <= '0;
            ref_q      <= '0;
            flt_q      <= '0;
            wgt_q      <= '0;
            clr_done_q <= 1'b0;
        end else begin
            clr_done_q <= (state == PVH_CLEAR) && at_last_bin;
            unique case (state)
                PVH_IDLE: begin
                    if (clr_start) begin
                        state <= PVH_CLEAR;
                        cnt   <= '0;
                    end else if (ro_start) begin
                        state <= PVH_RD_HOLD;
                        cnt   <= '0;
                    end else if (vx_valid) begin
                        state <= PVH_UPD_RD;
                        lane  <= '0;
                        ref_q <= vx_ref;
                        flt_q <= vx_flt;
                        wgt_q <= vx_wgt;
                    end
                end
                PVH_CLEAR: begin
                    cnt <= cnt + AW'(1);
                    if (at_last_bin) state <= PVH_IDLE;
                end
                PVH_UPD_RD: state <= PVH_UPD_WR;
                PVH_UPD_WR: begin
                    lane  <= lane + LW'(1);
                    state <= (lane == LAST_LANE) ? PVH_IDLE : PVH_UPD_RD;
                end
                PVH_RD_HOLD: begin
                    if (ro_ready) begin
                        if (at_last_bin) state <= PVH_IDLE;
                        else             cnt   <= cnt + AW'(1);
                    end
                end
                default: state <= PVH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pvh_checker.sv
// Protocol and arithmetic properties of the joint histogram accumulator.
module pvh_checker #(
    parameter int BIN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vx_valid,
    input logic             vx_ready,
    input logic             ro_valid,
    input logic             ro_ready,
    input logic [BIN_W-1:0] ro_data,
    input logic             ro_last,
    input logic             clr_done,
    input logic             upd_wr,
    input logic [BIN_W-1:0] old_val,
    input logic [BIN_W-1:0] new_val
);
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vx_valid && vx_ready |=> !vx_ready);

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ro_valid && !ro_ready |=> ro_valid && $stable(ro_data) && $stable(ro_last));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_wr |-> new_val >= old_val);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> !clr_done);

    assert_done_not_reading_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |-> !ro_valid);

    assert_stream_excludes_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ro_valid && vx_ready));

    assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ro_last |-> ro_valid);
endmodule

bind pv_joint_hist pvh_checker #(.BIN_W(BIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vx_valid(vx_valid), .vx_ready(vx_ready),
    .ro_valid(ro_valid), .ro_ready(ro_ready), .ro_data(ro_data),
    .ro_last(ro_last), .clr_done(clr_done), .upd_wr(upd_wr_s),
    .old_val(ram_q), .new_val(sum_val)
);

// File: tb/pv_joint_hist_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every bin with an arithmetic model.
module pv_joint_hist_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_start = 1'b0;
    logic        clr_done;
    logic        vx_valid = 1'b0;
    logic        vx_ready;
    logic [7:0]  vx_ref = '0;
    logic [63:0] vx_flt = '0;
    logic [63:0] vx_wgt = '0;
    logic        ro_start = 1'b0;
    logic        ro_valid;
    logic        ro_ready = 1'b0;
    logic [15:0] ro_data;
    logic        ro_last;

    int checks = 0;
    int failures = 0;
    int unsigned model [4096];
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pv_joint_hist uut (
        .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .clr_done(clr_done),
        .vx_valid(vx_valid), .vx_ready(vx_ready), .vx_ref(vx_ref),
        .vx_flt(vx_flt), .vx_wgt(vx_wgt), .ro_start(ro_start),
        .ro_valid(ro_valid), .ro_ready(ro_ready), .ro_data(ro_data),
        .ro_last(ro_last)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Clear all bins, offering a junk voxel event throughout (R2).
    task automatic do_clear();
        int n = 0;
        int ready_seen = 0;
        @(negedge clk);
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        vx_valid = 1'b1;
        vx_ref = 8'hFF;
        vx_flt = '1;
        vx_wgt = '1;
        while (!clr_done && n < 5000) begin
            if (vx_ready) ready_seen++;
            @(negedge clk);
            n++;
        end
        vx_valid = 1'b0;
        chk(n == 4096, "R2 clear done delay", n, 4096);
        chk(ready_seen == 0, "R2 ready low during clear", ready_seen, 0);
        @(negedge clk);
        chk(clr_done == 1'b0, "R2 done is one pulse", clr_done, 0);
        for (int i = 0; i < 4096; i++) model[i] = 0;
    endtask

    // Offer one voxel event and update the model (R3, R4, R5, R6, R7).
    task automatic send_voxel(input logic [7:0] r, input logic [63:0] f,
                              input logic [63:0] w, input bit timing);
        int n = 0;
        while (!vx_ready) @(negedge clk);
        vx_valid = 1'b1;
        vx_ref = r;
        vx_flt = f;
        vx_wgt = w;
        @(negedge clk);
        vx_valid = 1'b0;
        while (!vx_ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        if (timing) chk(n == 16, "R7 busy window", n, 16);
        for (int k = 0; k < 8; k++) begin
            int idx = int'(r[7:2]) * 64 + int'(f[k*8+2 +: 6]);
            int unsigned s = model[idx] + int'(w[k*8 +: 8]);
            model[idx] = (s > 65535) ? 65535 : s;
        end
    endtask

    // Stream every bin under a periodic stall and compare (R8, R9).
    task automatic do_readout(input string tag);
        int idx = 0;
        int n = 0;
        int bad = 0;
        bit prev_stall = 1'b0;
        logic [15:0] prev_data = '0;
        logic prev_last = 1'b0;
        @(negedge clk);
        ro_start = 1'b1;
        @(negedge clk);
        ro_start = 1'b0;
        chk(ro_valid == 1'b1, "R8 valid one cycle after start", ro_valid, 1);
        while (idx < 4096 && n < 20000) begin
            bit rdy = !((cyc % 7) == 2 || (cyc % 7) == 3);
            if (prev_stall && (ro_data !== prev_data || ro_last !== prev_last)) begin
                bad++;
                chk(1'b0, "R9 hold under stall", ro_data, prev_data);
            end
            ro_ready = rdy;
            if (ro_valid && rdy) begin
                if (ro_data !== 16'(model[idx])) begin
                    bad++;
                    chk(1'b0, tag, ro_data, model[idx]);
                end
                if (ro_last !== (idx == 4095)) begin
                    bad++;
                    chk(1'b0, "R8 last marker", ro_last, idx == 4095);
                end
                idx++;
            end
            prev_stall = ro_valid && !rdy;
            prev_data = ro_data;
            prev_last = ro_last;
            @(negedge clk);
            n++;
        end
        ro_ready = 1'b0;
        chk(idx == 4096, "R8 word count", idx, 4096);
        chk(bad == 0, tag, bad, 0);
        chk(ro_valid == 1'b0, "R8 back to idle", ro_valid, 0);
        chk(vx_ready == 1'b1, "R8 ready after stream", vx_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] f;
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(vx_ready == 1'b1, "R1 vx_ready", vx_ready, 1);
        chk(ro_valid == 1'b0, "R1 ro_valid", ro_valid, 0);
        chk(ro_last == 1'b0, "R1 ro_last", ro_last, 0);
        chk(clr_done == 1'b0, "R1 clr_done", clr_done, 0);

        do_clear();
        do_readout("R2 bins zero after clear");

        // R3 R4: every bin hit once; low intensity bits vary and are ignored.
        for (int r = 0; r < 64; r++) begin
            for (int v = 0; v < 8; v++) begin
                for (int k = 0; k < 8; k++) begin
                    f[k*8 +: 8] = 8'(((v*8 + k + r) % 64) * 4 + (k % 4));
                    w[k*8 +: 8] = 8'((r*7 + v*8 + k) % 256);
                end
                send_voxel(8'(r*4 + (r % 4)), f, w, (v == 0) && (r % 16 == 0));
            end
        end
        // R5: all lanes on one bin, then two pairs sharing bins.
        for (int k = 0; k < 8; k++) begin
            f[k*8 +: 8] = 8'(9*4 + k % 4);
            w[k*8 +: 8] = 8'(k + 1);
        end
        send_voxel(8'(5*4), f, w, 1'b1);
        for (int k = 0; k < 8; k++) begin
            f[k*8 +: 8] = 8'((k < 4) ? 20*4 : 30*4 + 3);
            w[k*8 +: 8] = 8'(10 * k + 3);
        end
        send_voxel(8'(40*4 + 2), f, w, 1'b0);
        // R6: drive bin (63,63) past full scale.
        for (int i = 0; i < 33; i++) send_voxel(8'hFF, '1, '1, 1'b0);
        chk(model[4095] == 65535, "R6 model saturates", model[4095], 65535);

        do_readout("R3 R4 R5 R6 bin contents");
        do_clear();
        do_readout("R2 bins zero after second clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule